// File: doc/BRIEF.md
# DAC Step Timer for Comparator-Based Linearity Test

This block runs the digital side of a linearity test for a digital-to-analog converter. It drives the converter's input code. A slow, rising analog ramp and the converter output feed an external comparator, and the block watches that comparator's output. Each time the comparator output goes from low to high, the block stores a free-running cycle index. The index is stored in a slot chosen by the code that was pending at that moment. The block then moves on to the next code. The stored indices are the times at which the ramp crossed each output level, and software later turns them into DNL and INL figures.

A pass starts with the index at zero. It ends on an external end-of-ramp strobe or when the index reaches a programmed limit. A non-monotonic converter, or a step too small to produce a comparator edge, leaves a code unrecorded. A pass that ends that way leaves the code counter at that code. A later pass started without a reload resumes from it. Each slot carries a valid flag, so the controlling agent can see which codes are still missing. A completion flag reports when every code has been captured, the code counter has wrapped back to the first code, and the comparator is high at the end of the ramp.

Top module: `dac_step_timer`

## Requirements
- R1: While idle, `load_i` sets `dac_code_o` to `first_code_i` on the next cycle and clears every slot's valid flag.
- R2: While idle, `start_i` begins a pass. `busy_o` rises and `done_o` clears on the next cycle, and the cycle index restarts at zero. The code is not reloaded.
- R3: `cmp_i` passes through a two-stage synchronizer. Suppose `cmp_i` is first sampled high at clock edge N, `start_i` was sampled at edge S, and the pass is still running. Then the slot of the pending code receives the value N-S+1 and is marked valid, and `dac_code_o` advances by one modulo 2^CODE_W.
- R4: `rd_idx_o` and `rd_vld_o` show, without a clock delay, the stored index and valid flag of the slot addressed by `rd_addr_i`.
- R5: A pass ends on the cycle in which `ramp_end_i` is high, or in which the index equals `limit_i`. On the next cycle `busy_o` is low and `done_o` is high. A synchronized rising edge that falls in that ending cycle is not recorded.
- R6: When a pass ends, `complete_o` is set only if the pending code equals the last loaded first code, the synchronized comparator is high, and all slots are valid. Otherwise it is cleared.
- R7: A pass started without a reload keeps the pending code, so its first comparator edge is stored in the slot of the code the previous pass missed.
- R8: `load_i` and `start_i` have no effect while a pass is running: the code does not change and the index is not restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Load the first code and clear valid flags (idle only) |
| first_code_i | input | CODE_W | First code of the sweep |
| start_i | input | 1 | Begin a pass (idle only) |
| cmp_i | input | 1 | Asynchronous comparator output, high when ramp exceeds DAC output |
| ramp_end_i | input | 1 | End-of-ramp strobe |
| limit_i | input | IDX_W | Index value at which a pass ends |
| dac_code_o | output | CODE_W | Code driven to the DAC under test (next pending code) |
| rd_addr_i | input | CODE_W | Read address into the timestamp slots |
| rd_idx_o | output | IDX_W | Stored index of the addressed slot |
| rd_vld_o | output | 1 | Valid flag of the addressed slot |
| busy_o | output | 1 | A pass is running |
| done_o | output | 1 | The last pass has ended |
| complete_o | output | 1 | All codes captured and sweep wrapped at the end of the last pass |

## Verification
On every cycle the assertions check the cycle-level rules:
- the index restarts on an accepted start and steps by one while a pass runs;
- each recorded edge writes a valid slot and advances the code by exactly one;
- a load or start arriving during a pass leaves the code alone;
- an end condition drops `busy_o` and raises `done_o`.

Only the bench scenarios can show that the stored values equal the true crossing times measured from the start edge. They also show that a second pass resumes from the missed code, that the completion flag follows the wrap and the comparator level, and that an edge coinciding with the end strobe is dropped.

// File: rtl/dst_pkg.sv
`timescale 1ns/1ps
package dst_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } dst_state_t;
endpackage

// File: rtl/dst_cmp_sync.sv
`timescale 1ns/1ps
module dst_cmp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic level_o,
   output logic rise_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dst_cmp_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign level_o = chain_q[STAGES-1];
   assign rise_o  = chain_q[STAGES-1] & ~prev_q;

   // R3: a rise is a single-cycle event
   assert_rise_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/dst_code_ctr.sv
`timescale 1ns/1ps
module dst_code_ctr #(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [CODE_W-1:0] load_val,
   input  logic              step,
   output logic [CODE_W-1:0] code_o,
   output logic [CODE_W-1:0] first_o
);
   logic [CODE_W-1:0] code_q, first_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q  <= '0;
         first_q <= '0;
      end else if (load_en) begin
         code_q  <= load_val;
         first_q <= load_val;
      end else if (step) begin
         code_q  <= code_q + 1'b1;
      end
   end

   assign code_o  = code_q;
   assign first_o = first_q;

   // R3: one step moves the code by exactly one
   assert_code_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load_en) |=> code_o == CODE_W'($past(code_o) + 1'b1));
   // R1: a load lands the requested first code
   assert_code_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> (code_o == $past(load_val)) && (first_o == $past(load_val)));
endmodule

// File: rtl/dst_stamp_mem.sv
`timescale 1ns/1ps
module dst_stamp_mem #(
   parameter int CODE_W = 8,
   parameter int IDX_W  = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              we,
   input  logic [CODE_W-1:0] wr_addr,
   input  logic [IDX_W-1:0]  wr_data,
   input  logic [CODE_W-1:0] rd_addr,
   output logic [IDX_W-1:0]  rd_data,
   output logic              rd_vld,
   output logic              all_vld
);
   localparam int DEPTH = 1 << CODE_W;

   logic [IDX_W-1:0] slot_q [DEPTH];
   logic [DEPTH-1:0] vld_q;

   always_ff @(posedge clk) begin
      if (we) slot_q[wr_addr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   vld_q <= '0;
      else if (clr) vld_q <= '0;
      else if (we)  vld_q[wr_addr] <= 1'b1;
   end

   assign rd_data = slot_q[rd_addr];
   assign rd_vld  = vld_q[rd_addr];
   assign all_vld = &vld_q;

   // R3: a written slot is flagged valid
   assert_slot_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !clr) |=> vld_q[$past(wr_addr)]);
   // R1: a clear leaves no valid slot
   assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (vld_q == '0));
endmodule

// File: rtl/dac_step_timer.sv
`timescale 1ns/1ps
module dac_step_timer #(
   parameter int CODE_W      = 8,
   parameter int IDX_W       = 14,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [CODE_W-1:0] first_code_i,
   input  logic              start_i,
   input  logic              cmp_i,
   input  logic              ramp_end_i,
   input  logic [IDX_W-1:0]  limit_i,
   output logic [CODE_W-1:0] dac_code_o,
   input  logic [CODE_W-1:0] rd_addr_i,
   output logic [IDX_W-1:0]  rd_idx_o,
   output logic              rd_vld_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              complete_o
);
   import dst_pkg::*;

   if (CODE_W < 1 || CODE_W > 12) begin : g_bad_code_w
      $error("dac_step_timer: CODE_W out of range 1..12");
   end
   if (IDX_W < 2 || IDX_W > 32) begin : g_bad_idx_w
      $error("dac_step_timer: IDX_W out of range 2..32");
   end

   dst_state_t        state_q;
   logic [IDX_W-1:0]  idx_q;
   logic              done_q, complete_q;
   logic              cmp_level, cmp_rise;
   logic [CODE_W-1:0] code, first_code;
   logic              all_vld;
   logic              idle, load_ok, start_ok, end_now, record;

   assign idle     = (state_q == ST_IDLE);
   assign load_ok  = idle & load_i;
   assign start_ok = idle & start_i;
   assign end_now  = !idle & (ramp_end_i | (idx_q == limit_i));
   assign record   = !idle & cmp_rise & ~end_now;

   dst_cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (cmp_i),
      .level_o (cmp_level),
      .rise_o  (cmp_rise)
   );

   dst_code_ctr #(.CODE_W(CODE_W)) u_code (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (load_ok),
      .load_val (first_code_i),
      .step     (record),
      .code_o   (code),
      .first_o  (first_code)
   );

   dst_stamp_mem #(.CODE_W(CODE_W), .IDX_W(IDX_W)) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (load_ok),
      .we      (record),
      .wr_addr (code),
      .wr_data (idx_q),
      .rd_addr (rd_addr_i),
      .rd_data (rd_idx_o),
      .rd_vld  (rd_vld_o),
      .all_vld (all_vld)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         idx_q      <= '0;
         done_q     <= 1'b0;
         complete_q <= 1'b0;
      end else if (start_ok) begin
         state_q    <= ST_RUN;
         idx_q      <= '0;
         done_q     <= 1'b0;
         complete_q <= 1'b0;
      end else if (end_now) begin
         state_q    <= ST_IDLE;
         done_q     <= 1'b1;
         complete_q <= (code == first_code) & cmp_level & all_vld;
      end else if (!idle) begin
         idx_q      <= idx_q + 1'b1;
      end
   end

   assign dac_code_o = code;
   assign busy_o     = !idle;
   assign done_o     = done_q;
   assign complete_o = complete_q;

   // R2: an accepted start restarts the index and raises busy
   assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start_ok |=> (idx_q == '0) && busy_o && !done_o);
   // R3: index steps by one during a running pass
   assert_idx_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && !end_now) |=> idx_q == IDX_W'($past(idx_q) + 1'b1));
   // R5: an end condition stops the pass
   assert_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
      end_now |=> !busy_o && done_o);
   // R8: load has no effect on the code while running
   assert_load_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && !record) |=> $stable(dac_code_o));
endmodule

// File: tb/tb_dac_step_timer.sv
`timescale 1ns/1ps
module tb_dac_step_timer;
   localparam int CW = 3;
   localparam int IW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          load_i = 1'b0;
   logic [CW-1:0] first_code_i = '0;
   logic          start_i = 1'b0;
   logic          cmp_i = 1'b0;
   logic          ramp_end_i = 1'b0;
   logic [IW-1:0] limit_i = IW'(100);
   logic [CW-1:0] dac_code_o;
   logic [CW-1:0] rd_addr_i = '0;
   logic [IW-1:0] rd_idx_o;
   logic          rd_vld_o, busy_o, done_o, complete_o;

   dac_step_timer #(.CODE_W(CW), .IDX_W(IW)) dut (.*);

   always #2 clk = ~clk;

   int checks = 0, errors = 0, cyc = 0, start_cyc = 0;
   logic [CW-1:0] exp_code;
   int q_code[$];
   int q_stamp[$];
   bit finished = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_start();
      start_i = 1'b1; start_cyc = cyc; tick(1); start_i = 1'b0;
   endtask

   // driver: one comparator pulse, pushes expected slot contents
   task automatic pulse(bit hold);
      q_code.push_back(int'(exp_code));
      q_stamp.push_back(cyc - start_cyc + 1);
      cmp_i = 1'b1; tick(4);
      exp_code = exp_code + 1'b1;
      check("R3 code advance", dac_code_o, exp_code);
      if (!hold) begin cmp_i = 1'b0; tick(4); end
   endtask

   // monitor: pops expected items and compares through the read port
   task automatic drain();
      while (q_code.size() > 0) begin
         int c, s;
         c = q_code.pop_front(); s = q_stamp.pop_front();
         rd_addr_i = CW'(c); #1;
         check("R4 slot valid", rd_vld_o, 1);
         check("R3 stamp", rd_idx_o, s);
      end
   endtask

   initial begin
      #20000;
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      tick(3); rst_n = 1'b1; tick(1);
      check("reset busy", busy_o, 0);
      check("reset done", done_o, 0);
      check("reset complete", complete_o, 0);
      check("reset code", dac_code_o, 0);
      check("R4 reset valid", rd_vld_o, 0);

      // R1: load first code 5
      first_code_i = CW'(5); load_i = 1'b1; tick(1); load_i = 1'b0;
      check("R1 load code", dac_code_o, 5);
      exp_code = CW'(5);

      // pass 1: codes 5,6,7 then end by strobe
      do_start();
      check("R2 busy", busy_o, 1);
      check("R2 code kept", dac_code_o, 5);
      tick(3);
      pulse(0); tick(2); pulse(0); pulse(0);
      ramp_end_i = 1'b1; tick(1); ramp_end_i = 1'b0;
      check("R5 busy low", busy_o, 0);
      check("R5 done", done_o, 1);
      check("R6 not complete", complete_o, 0);
      check("R7 pending code", dac_code_o, 0);
      rd_addr_i = CW'(0); #1;
      check("R4 missing code invalid", rd_vld_o, 0);
      drain();

      // pass 2: rerun without reload, ignored load/start, end by limit
      do_start();
      check("R2 done cleared", done_o, 0);
      check("R7 code kept on rerun", dac_code_o, 0);
      tick(2);
      pulse(0);
      first_code_i = CW'(2); load_i = 1'b1; tick(1); load_i = 1'b0;
      check("R8 load ignored", dac_code_o, 1);
      start_i = 1'b1; tick(1); start_i = 1'b0;
      pulse(0); pulse(0); pulse(0); pulse(1);
      while (busy_o) tick(1);
      check("R5 done by limit", done_o, 1);
      check("R6 complete", complete_o, 1);
      check("R6 wrapped", dac_code_o, 5);
      drain();

      // R1: reload clears valid flags
      cmp_i = 1'b0;
      first_code_i = CW'(0); load_i = 1'b1; tick(1); load_i = 1'b0;
      rd_addr_i = CW'(5); #1;
      check("R1 valid cleared", rd_vld_o, 0);
      check("R1 reload code", dac_code_o, 0);
      tick(4);

      // R5: rise coinciding with the ending cycle is dropped
      do_start(); tick(3);
      cmp_i = 1'b1; tick(2);
      ramp_end_i = 1'b1; tick(1); ramp_end_i = 1'b0;
      check("R5 edge at end dropped code", dac_code_o, 0);
      rd_addr_i = CW'(0); #1;
      check("R5 edge at end not stored", rd_vld_o, 0);
      check("R6 incomplete", complete_o, 0);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule